// File: doc/BRIEF.md
# Page Buffer Load and Commit Controller

This block is the page-write front end of a byte-wide, nonvolatile-style memory. A host writes bytes with active-low chip-select, write and read strobes, sampled on the system clock. The first byte it accepts opens a load period. That byte fixes the page, which is the upper seven bits of the 13-bit address. Later bytes go into a 64-entry page register. Each entry has its own valid bit. Bytes may arrive in any order, and a byte may be rewritten any number of times. When no new byte has been accepted for a set number of clock cycles, loading closes and a self-timed programming cycle begins. During that cycle the controller drives a single array write port once for each loaded byte, and for no other byte. It holds `busy` high for the full programming time, and then clears the page register.

An authorisation input comes from a separate unlock detector. When a first byte ends while this input is low, the controller writes no data. It still runs a complete programming cycle, so `busy` stays high for the whole programming time. The byte-load window (`LOAD_TIMEOUT`) and the programming time (`PROG_CYCLES`) are parameters counted in clock cycles. `PROG_CYCLES` must be larger than the page size.

The controller has four states:
- **IDLE** goes to LOAD on an authorised first byte (*open*), or to SCAN on an unauthorised one (*blank start*).
- **LOAD** goes to SCAN when the load window expires (*timeout*).
- **SCAN** walks through the page offsets and goes to WAIT after offset 63 (*scan done*).
- **WAIT** goes back to IDLE when the programming time has run out (*commit done*). The valid bits and the page are cleared on this transition.

Top module: `page_commit_ctrl`

## Requirements
- R1: While reset is held and in the first cycles after it, `busy` is low and `arr_we` is low.
- R2: A write pulse is the period in which `ce_n` and `we_n` are both low. The address is captured in the first clock cycle of the pulse. The data is the `din` value sampled in the last cycle of the pulse. Address changes later in the pulse, and data values before its last cycle, have no effect.
- R3: A pulse during which `oe_n` is sampled low in any cycle is discarded. Nothing is loaded or started, and the load window is not restarted by its end.
- R4: In IDLE, the end of a valid pulse with `unlock_ok` high opens a load. The page is `addr[12:6]` and the offset is `addr[5:0]`. During the load, further bytes of the same page are accepted at any offset and in any order. A rewritten offset keeps its last data.
- R5: During a load, a pulse whose page bits differ from the open page is dropped.
- R6: Programming (`busy` high) begins exactly `LOAD_TIMEOUT` clock edges after the edge that accepted the last byte. The load window is held at zero while a pulse is in progress.
- R7: `busy` stays high for exactly `PROG_CYCLES` cycles. In busy cycle k, for k from 0 to 63, `arr_we` is high exactly when offset k was loaded, with `arr_addr` = {page, k} and `arr_wdata` = the last data loaded at k. There are no other array writes.
- R8: Write pulses that end while `busy` is high are ignored.
- R9: A valid pulse that ends in IDLE with `unlock_ok` low starts a full `PROG_CYCLES` busy period with no array write.
- R10: After a commit, the valid bits and the page are cleared. The next load writes only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low; when low it blocks writes |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in the lower OFFS_W bits |
| din | input | DATA_W | Write data |
| unlock_ok | input | 1 | Authorisation from the unlock detector, sampled when the first byte ends |
| busy | output | 1 | High for the whole programming cycle |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The hardest case to reach is a load that mixes every kind of byte in one window. Such a load contains an accepted byte, a byte for a foreign page, a byte blocked by the read strobe, and a rewrite of an earlier offset. All of these must arrive close enough together that the window never expires between them. The stimulus chains fixed-length pulses back to back, so that each gap stays below the window. It also changes the address and data inside each pulse, so that a wrong capture point lands on a different location. A behavioural model then predicts the exact cycle of the timeout and every write of the scan. A pulse issued in the middle of the programming cycle shows that the busy period is ignored for writes.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SCAN = 2'd2,
        ST_WAIT = 2'd3
    } pbc_state_e;

endpackage

// File: rtl/pbc_counter.sv
module pbc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/pbc_strobe.sv
module pbc_strobe #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              act,
    output logic              evt,
    output logic              evt_ok,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic act_q;
    logic oe_seen;

    // The pulse is the overlap of both strobes: it starts at the later
    // falling edge and ends at the earlier rising edge.
    assign act    = ~ce_n & ~we_n;
    assign evt    = ~act & act_q;
    assign evt_ok = ~oe_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            oe_seen  <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                cap_addr <= addr;
                oe_seen  <= ~oe_n;
            end else if (act) begin
                oe_seen  <= oe_seen | ~oe_n;
            end
            if (act) begin
                cap_data <= din;
            end
        end
    end

endmodule

// File: rtl/pbc_page_buf.sv
module pbc_page_buf #(
    parameter int OFFS_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFFS_W-1:0] rd_off,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << OFFS_W;

    logic [DEPTH-1:0]  vld_w;
    logic [DATA_W-1:0] dat_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic              v;
        logic [DATA_W-1:0] d;
        logic              hit;

        assign hit = wr_en && (wr_off == OFFS_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v <= 1'b0;
                d <= '0;
            end else if (clr) begin
                v <= 1'b0;
            end else if (hit) begin
                v <= 1'b1;
                d <= wr_data;
            end
        end

        assign vld_w[i] = v;
        assign dat_w[i] = d;
    end

    assign rd_valid = vld_w[rd_off];
    assign rd_data  = dat_w[rd_off];

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pbc_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int OFFS_W       = 6,
    parameter int LOAD_TIMEOUT = 5000,
    parameter int PROG_CYCLES  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              unlock_ok,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int PAGE_BYTES = 1 << OFFS_W;
    localparam int PAGE_W     = ADDR_W - OFFS_W;
    localparam int TMR_W      = $clog2(LOAD_TIMEOUT + 1);
    localparam int PC_W       = $clog2(PROG_CYCLES + 1);

    pbc_state_e state, state_nx;

    logic              act, evt, evt_ok;
    logic [ADDR_W-1:0] evt_addr;
    logic [DATA_W-1:0] evt_data;
    logic [PAGE_W-1:0] page_q;
    logic [TMR_W-1:0]  tmr;
    logic [PC_W-1:0]   pc;
    logic [OFFS_W-1:0] scan_off;
    logic              byte_ok, same_page;
    logic              accept_first, accept_more, blank_start;
    logic              tmr_clr, timeout_hit, pc_clr;
    logic              scan_last, wait_last;
    logic              buf_wr, buf_clr;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;

    pbc_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .din      (din),
        .act      (act),
        .evt      (evt),
        .evt_ok   (evt_ok),
        .cap_addr (evt_addr),
        .cap_data (evt_data)
    );

    // Decisions taken on the captured byte
    always_comb begin
        byte_ok      = evt && evt_ok;
        same_page    = (evt_addr[ADDR_W-1:OFFS_W] == page_q);
        accept_first = (state == ST_IDLE) && byte_ok && unlock_ok;
        blank_start  = (state == ST_IDLE) && byte_ok && !unlock_ok;
        accept_more  = (state == ST_LOAD) && byte_ok && same_page;
        tmr_clr      = (state != ST_LOAD) || accept_more || act;
        timeout_hit  = (state == ST_LOAD) && !tmr_clr && (tmr == TMR_W'(LOAD_TIMEOUT - 1));
        pc_clr       = (state != ST_SCAN) && (state != ST_WAIT);
        scan_last    = (pc == PC_W'(PAGE_BYTES - 1));
        wait_last    = (pc == PC_W'(PROG_CYCLES - 1));
        buf_wr       = accept_first || accept_more;
        buf_clr      = (state == ST_WAIT) && wait_last;
        scan_off     = pc[OFFS_W-1:0];
    end

    pbc_counter #(.W(TMR_W)) u_load_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (1'b1),
        .count (tmr)
    );

    pbc_counter #(.W(PC_W)) u_prog_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pc_clr),
        .inc   (1'b1),
        .count (pc)
    );

    pbc_page_buf #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr),
        .wr_off   (evt_addr[OFFS_W-1:0]),
        .wr_data  (evt_data),
        .clr      (buf_clr),
        .rd_off   (scan_off),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept_first) begin
                    state_nx = ST_LOAD;
                end else if (blank_start) begin
                    state_nx = ST_SCAN;
                end
            end
            ST_LOAD: begin
                if (timeout_hit) begin
                    state_nx = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_last) begin
                    state_nx = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wait_last) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Page register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (accept_first) begin
            page_q <= evt_addr[ADDR_W-1:OFFS_W];
        end else if (buf_clr) begin
            page_q <= '0;
        end
    end

    // Outputs, from registered state only
    always_comb begin
        busy      = (state == ST_SCAN) || (state == ST_WAIT);
        arr_we    = (state == ST_SCAN) && rd_valid;
        arr_addr  = {page_q, scan_off};
        arr_wdata = rd_data;
    end

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
    parameter int ADDR_W      = 13,
    parameter int OFFS_W      = 6,
    parameter int PROG_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= 0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end else begin
            busy_len <= 0;
        end
    end

    AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);  // R7

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == PROG_CYCLES));  // R7

    AST_BUSY_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);  // R9

    AST_SAME_PAGE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:OFFS_W] == $past(arr_addr[ADDR_W-1:OFFS_W])));  // R7

    AST_ASCENDING_OFFSETS: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[OFFS_W-1:0] > $past(arr_addr[OFFS_W-1:0])));  // R7

endmodule

bind page_commit_ctrl pbc_checker #(
    .ADDR_W      (ADDR_W),
    .OFFS_W      (OFFS_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_pbc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;

    localparam int LT = 20;
    localparam int PC = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic        unlock_ok = 1'b0;
    logic        busy, arr_we;
    logic [12:0] arr_addr;
    logic [7:0]  arr_wdata;

    always #10 clk = ~clk;

    page_commit_ctrl #(
        .ADDR_W(13), .DATA_W(8), .OFFS_W(6), .LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .unlock_ok(unlock_ok), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    int nchk = 0;
    int nfail = 0;
    bit chk_on = 1'b0;
    int wr_count = 0;
    logic [7:0] shadow [int];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    int       m_st, m_tmr, m_pc;
    int       m_page;
    bit       mval [64];
    int       mbuf [64];
    bit       m_actq, m_oebad;
    int       m_addrl, m_datal;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_pc = 0; m_page = 0;
            m_actq = 0; m_oebad = 0; m_addrl = 0; m_datal = 0;
            for (int i = 0; i < 64; i++) begin mval[i] = 0; mbuf[i] = 0; end
        end else begin
            bit a, e, ok;
            int pg, off;
            a  = !ce_n && !we_n;
            e  = !a && m_actq;
            ok = !m_oebad;
            pg = m_addrl / 64;
            off = m_addrl % 64;
            case (m_st)
                0: if (e && ok) begin
                    if (unlock_ok) begin
                        m_page = pg; mval[off] = 1; mbuf[off] = m_datal; m_st = 1; m_tmr = 0;
                    end else begin
                        m_st = 2; m_pc = 0;
                    end
                end
                1: begin
                    if (e && ok && pg == m_page) begin
                        mval[off] = 1; mbuf[off] = m_datal; m_tmr = 0;
                    end else if (a) m_tmr = 0;
                    else if (m_tmr == LT - 1) begin m_st = 2; m_pc = 0; end
                    else m_tmr++;
                end
                default: begin
                    if (m_pc == PC - 1) begin
                        m_st = 0; m_page = 0;
                        for (int i = 0; i < 64; i++) mval[i] = 0;
                    end else m_pc++;
                end
            endcase
            if (a && !m_actq) begin m_addrl = addr; m_oebad = !oe_n; end
            else if (a && !oe_n) m_oebad = 1;
            if (a) m_datal = din;
            m_actq = a;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            bit ew;
            ew = (m_st == 2) && (m_pc < 64) && mval[m_pc % 64];
            chk(busy == (m_st == 2), "R6 R7 R9", "busy", busy, m_st == 2);
            chk(arr_we == ew, "R7 R8 R10", "arr_we", arr_we, ew);
            if (ew && arr_we) begin
                chk(arr_addr == 13'(m_page * 64 + m_pc), "R7", "arr_addr", arr_addr, m_page * 64 + m_pc);
                chk(arr_wdata == 8'(mbuf[m_pc]), "R7", "arr_wdata", arr_wdata, mbuf[m_pc]);
            end
        end
        if (rst_n && arr_we) begin
            shadow[int'(arr_addr)] = arr_wdata;
            wr_count++;
        end
    end

    task automatic pulse(input logic [12:0] a, input logic [7:0] d, input logic ul, input logic glitch);
        @(negedge clk); addr = a; din = ~d; unlock_ok = ul; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = ~a; din = d; if (glitch) oe_n = 1'b0;
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1; unlock_ok = 1'b0; din = '0;
    endtask

    task automatic run_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic chk_mem(input int a, input int exp, input string req);
        if (exp < 0) chk(!shadow.exists(a), req, $sformatf("untouched %0h", a), shadow.exists(a), 0);
        else chk(shadow.exists(a) && shadow[a] == 8'(exp), req, $sformatf("mem %0h", a),
                 shadow.exists(a) ? int'(shadow[a]) : -1, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(arr_we == 1'b0, "R1", "arr_we in reset", arr_we, 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && arr_we == 1'b0, "R1", "idle after reset", busy, 0);

        // Mixed load on page 5
        wr_count = 0;
        pulse(13'h143, 8'h11, 1'b1, 1'b0);   // R4 open, offset 3
        pulse(13'h141, 8'h22, 1'b0, 1'b0);   // R4 out of order
        pulse(13'h149, 8'h99, 1'b0, 1'b1);   // R3 read strobe low
        pulse(13'h182, 8'h77, 1'b0, 1'b0);   // R5 foreign page
        pulse(13'h17C, 8'h33, 1'b0, 1'b0);
        pulse(13'h143, 8'h44, 1'b0, 1'b0);   // R4 rewrite
        repeat (LT - 1) @(negedge clk);
        chk(busy == 1'b0, "R6", "still loading", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R6", "timeout starts busy", busy, 1);
        pulse(13'h145, 8'h55, 1'b1, 1'b0);   // R8 during busy
        run_busy(n);
        chk(n == PC - 6, "R7", "busy remaining", n, PC - 6);
        chk(wr_count == 3, "R7", "write count", wr_count, 3);
        chk_mem(13'h141, 8'h22, "R4");
        chk_mem(13'h143, 8'h44, "R4");
        chk_mem(13'h17C, 8'h33, "R2");
        chk_mem(13'h149, -1, "R3");
        chk_mem(13'h182, -1, "R5");
        chk_mem(int'(~13'h143), -1, "R2");
        chk_mem(13'h145, -1, "R8");
        repeat (LT + 5) @(negedge clk);
        chk(busy == 1'b0, "R8", "no load after busy pulse", busy, 0);

        // Unauthorised first byte
        wr_count = 0;
        pulse(13'h280, 8'hAB, 1'b0, 1'b0);
        chk(busy == 1'b1, "R9", "blank start busy", busy, 1);
        run_busy(n);
        chk(n == PC, "R9", "blank busy length", n, PC);
        chk(wr_count == 0, "R9", "blank writes", wr_count, 0);
        chk_mem(13'h280, -1, "R9");

        // Fresh load after clear
        wr_count = 0;
        pulse(13'h14A, 8'h5A, 1'b1, 1'b0);
        repeat (LT) @(negedge clk);
        chk(busy == 1'b1, "R6", "second timeout", busy, 1);
        run_busy(n);
        chk(n == PC, "R7", "busy length", n, PC);
        chk(wr_count == 1, "R10", "only new byte written", wr_count, 1);
        chk_mem(13'h14A, 8'h5A, "R10");

        // Read strobe low on a first byte
        wr_count = 0;
        pulse(13'h0C0, 8'hC3, 1'b1, 1'b1);
        repeat (LT + 5) @(negedge clk);
        chk(busy == 1'b0, "R3", "no start on blocked pulse", busy, 0);
        chk(wr_count == 0, "R3", "no write on blocked pulse", wr_count, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule